// File: doc/BRIEF.md
# Command ring fetch pointer controller

This block tracks a circular ring of 256 command dwords in memory. Software fills the ring and a fetch engine drains it. Software advances a write pointer to the offset of the last command it has placed. The engine then reads dwords one at a time through a memory-read port until its read pointer catches up with the write pointer. Every dword that returns lands in a small prefetch buffer, and a downstream consumer takes the dwords from there with a valid/ready handshake.

Both pointers name an entry already in use, not the next free slot. Before each fetch the read pointer is incremented modulo 256, and the entry at the new offset is read from `base + 4*offset`. The read pointer can only go back to zero through a handshake. Software sets the reset bit while the engine is stopped, waits until the bit reads back as 1, and then clears it again. The same handshake empties the prefetch buffer.

A run input gates new fetches. A fetch that is already outstanding still completes, and the engine only counts as stopped after that.

Top module: `cmd_ring_ctrl`

## Requirements
- R1: After reset both registers read 0000h, `mem_req_o` is 0 and `cmd_valid_o` is 0.
- R2: With `reg_sel_i`=0 the register holds the write pointer in bits 7:0, and software can read and write it, also while the engine runs. Bits 15:8 always read 0.
- R3: A request holds `mem_req_o` high with a stable `mem_addr_o` until `mem_rvalid_i`. Only one request is outstanding at a time. The address equals `base_addr_i + 4*((rp+1) mod 256)`, and `mem_rdata_i` returns the dword stored at that address.
- R4: Each returned dword advances the read pointer by one modulo 256. Fetching stops once the read pointer equals the write pointer, and no further request is issued.
- R5: Fetched dwords leave on `cmd_data_o` in ring order. The buffer holds 4 dwords. While it is full no request is issued, and a held `cmd_valid_o` keeps its data stable.
- R6: While `run_i` is 0 no new request starts. An outstanding request still completes. `engine_active_o` stays 1 until that request completes.
- R7: With `reg_sel_i`=1, bits 7:0 read the read pointer and bits 14:8 read 0. Writes to bits 14:0 have no effect.
- R8: Writing 1 to bit 15 of the `reg_sel_i`=1 register while `engine_active_o` is 0 sets the read pointer to 0 and empties the buffer at that write's clock edge. Bit 15 reads 0 in the cycle right after that edge and reads 1 from the cycle after that.
- R9: Writing 0 to bit 15 makes the bit read 0 from the next cycle on. While bit 15 is 1, or its reset is still pending, no request is issued.
- R10: Writing 1 to bit 15 while `engine_active_o` is 1 is ignored. The bit stays 0, and the read pointer and the buffer keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 write pointer, 1 read pointer |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Selected register, combinational read |
| run_i | input | 1 | Allows new fetches |
| engine_active_o | output | 1 | Run high or a fetch outstanding |
| base_addr_i | input | 32 | Ring base byte address |
| mem_req_o | output | 1 | Fetch request, held until data returns |
| mem_addr_o | output | 32 | Fetch byte address |
| mem_rvalid_i | input | 1 | Fetch data valid, ends the request |
| mem_rdata_i | input | 32 | Fetched dword |
| cmd_valid_o | output | 1 | Buffered command available |
| cmd_data_o | output | 32 | Oldest buffered command |
| cmd_ready_i | input | 1 | Consumer takes the command |

## Verification
A table of write-pointer updates drives the fetch loop over a series of spans:
- a short span, which shows that the stop condition is exact;
- a write that leaves the pointer unchanged, which shows that an equal pointer issues nothing;
- a long span;
- a span that crosses offset 255, which separates a correct modulo-256 wrap from a wrong one.

The memory model returns each dword tagged with its own address. A dropped, repeated or misaddressed fetch therefore shows up as a data mismatch at the consumer. Directed cases cover:
- a stalled consumer, for the full-buffer stop;
- both outcomes of a reset request, with the engine stopped and with it running;
- the fetch lock while bit 15 is held;
- a stop that arrives during a slow fetch.

// File: rtl/cmd_ring_pkg.sv
package cmd_ring_pkg;
  typedef enum logic {
    SEL_WP = 1'b0,
    SEL_RP = 1'b1
  } reg_sel_e;

  localparam int unsigned REG_W   = 16;
  localparam int unsigned RST_BIT = 15;
endpackage

// File: rtl/cmd_ring_regs.sv
module cmd_ring_regs
  import cmd_ring_pkg::*;
#(
  parameter int unsigned PTR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic             reg_sel_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  input  logic             engine_active_i,
  input  logic [PTR_W-1:0] rp_i,
  output logic [PTR_W-1:0] wp_o,
  output logic             flush_o,
  output logic             hold_o,
  output logic [REG_W-1:0] reg_rdata_o
);
  logic [PTR_W-1:0] wp_q;
  logic             pend_q, done_q;
  logic             wr_wp, wr_rp, rst_accept, rst_clear;
  logic             unused_wdata;

  assign unused_wdata = ^reg_wdata_i[RST_BIT-1:PTR_W];

  assign wr_wp      = reg_we_i && (reg_sel_i == SEL_WP);
  assign wr_rp      = reg_we_i && (reg_sel_i == SEL_RP);
  assign rst_accept = wr_rp && reg_wdata_i[RST_BIT] && !engine_active_i;
  assign rst_clear  = wr_rp && !reg_wdata_i[RST_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0;
    end else if (wr_wp) begin
      wp_q <= reg_wdata_i[PTR_W-1:0];
    end
  end

  // pend: flush done this edge, flag follows one cycle later
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      done_q <= 1'b0;
    end else if (rst_clear) begin
      pend_q <= 1'b0;
      done_q <= 1'b0;
    end else if (rst_accept) begin
      pend_q <= 1'b1;
    end else if (pend_q) begin
      pend_q <= 1'b0;
      done_q <= 1'b1;
    end
  end

  assign wp_o    = wp_q;
  assign flush_o = rst_accept;
  assign hold_o  = pend_q || done_q;

  always_comb begin
    reg_rdata_o = '0;
    if (reg_sel_i == SEL_WP) begin
      reg_rdata_o[PTR_W-1:0] = wp_q;
    end else begin
      reg_rdata_o[PTR_W-1:0] = rp_i;
      reg_rdata_o[RST_BIT]   = done_q;
    end
  end

  AST_RST_ZEROES_RP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_accept |=> (rp_i == '0)); // R8
  AST_FLAG_AFTER_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(rst_accept) || $past(pend_q)); // R8
  AST_MISUSE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_rp && reg_wdata_i[RST_BIT] && engine_active_i && !pend_q && !done_q) |=> !done_q && !pend_q); // R10
endmodule

// File: rtl/cmd_ring_fifo.sv
module cmd_ring_fifo #(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o
);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [IDX_W-1:0]  wr_q, rd_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              do_pop;

  assign do_pop = pop_i && (cnt_q != '0);

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (push_i && (wr_q == IDX_W'(g))) mem_q[g] <= data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (do_pop) rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      case ({push_i, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign valid_o = (cnt_q != '0);
  assign data_o  = mem_q[rd_q];
  assign full_o  = (cnt_q == FULL);

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o || do_pop); // R5
  AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !valid_o); // R8
endmodule

// File: rtl/cmd_ring_fetch.sv
module cmd_ring_fetch #(
  parameter int unsigned PTR_W  = 8,
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [PTR_W-1:0]  wp_i,
  input  logic              hold_i,
  input  logic              flush_i,
  input  logic              buf_full_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic              mem_rvalid_i,
  output logic [PTR_W-1:0]  rp_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              push_o,
  output logic              active_o
);
  localparam int unsigned OFF_W = PTR_W + 2;

  logic [PTR_W-1:0]  rp_q, rp_next;
  logic              busy_q, issue, ret;
  logic [ADDR_W-1:0] addr_q;

  assign rp_next = rp_q + 1'b1;
  assign issue   = run_i && !busy_q && !hold_i && !buf_full_i && (rp_q != wp_i);
  assign ret     = busy_q && mem_rvalid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rp_q <= '0;
    end else if (flush_i) begin
      rp_q <= '0;
    end else if (ret) begin
      rp_q <= rp_next;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      addr_q <= '0;
    end else if (issue) begin
      busy_q <= 1'b1;
      addr_q <= base_addr_i + ADDR_W'(OFF_W'({rp_next, 2'b00}));
    end else if (ret) begin
      busy_q <= 1'b0;
    end
  end

  assign rp_o       = rp_q;
  assign mem_req_o  = busy_q;
  assign mem_addr_o = addr_q;
  assign push_o     = ret;
  assign active_o   = run_i || busy_q;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i) |=> mem_req_o && $stable(mem_addr_o)); // R3
  AST_IDLE_AT_WP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rp_q == wp_i) && !mem_req_o) |=> !mem_req_o); // R4
  AST_RUN_LOW_NO_NEW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !mem_req_o) |=> !mem_req_o); // R6
  AST_HOLD_NO_NEW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !mem_req_o) |=> !mem_req_o); // R9
endmodule

// File: rtl/cmd_ring_ctrl.sv
module cmd_ring_ctrl
  import cmd_ring_pkg::*;
#(
  parameter int unsigned PTR_W     = 8,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned BUF_DEPTH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_sel_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              run_i,
  output logic              engine_active_o,
  input  logic [ADDR_W-1:0] base_addr_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              cmd_valid_o,
  output logic [DATA_W-1:0] cmd_data_o,
  input  logic              cmd_ready_i
);
  logic [PTR_W-1:0] wp, rp;
  logic             flush, hold, buf_full, push, active;

  cmd_ring_regs #(.PTR_W(PTR_W)) u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_sel_i, .reg_wdata_i,
    .engine_active_i(active),
    .rp_i           (rp),
    .wp_o           (wp),
    .flush_o        (flush),
    .hold_o         (hold),
    .reg_rdata_o
  );

  cmd_ring_fetch #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_fetch (
    .clk_i, .rst_ni, .run_i,
    .wp_i        (wp),
    .hold_i      (hold),
    .flush_i     (flush),
    .buf_full_i  (buf_full),
    .base_addr_i,
    .mem_rvalid_i,
    .rp_o        (rp),
    .mem_req_o,
    .mem_addr_o,
    .push_o      (push),
    .active_o    (active)
  );

  cmd_ring_fifo #(.DEPTH(BUF_DEPTH), .DATA_W(DATA_W)) u_buf (
    .clk_i, .rst_ni,
    .flush_i (flush),
    .push_i  (push),
    .data_i  (mem_rdata_i),
    .pop_i   (cmd_ready_i),
    .valid_o (cmd_valid_o),
    .data_o  (cmd_data_o),
    .full_o  (buf_full)
  );

  assign engine_active_o = active;

  AST_CMD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_ready_i && !flush) |=> cmd_valid_o && $stable(cmd_data_o)); // R5
endmodule

// File: tb/cmd_ring_ctrl_bench.sv
`timescale 1ns/1ps
module cmd_ring_ctrl_bench;
  localparam logic [31:0] BASE = 32'h0001_0000;
  localparam logic [31:0] KEY  = 32'h5A00_0000;
  localparam int NVEC = 5;
  // {write pointer, expected dwords delivered}
  localparam logic [15:0] VEC [NVEC] = '{16'h0303, 16'h0300, 16'h0A07, 16'hFFF5, 16'h0203};

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_we = 1'b0, reg_sel = 1'b0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic        run = 1'b0, engine_active;
  logic        mem_req, mem_rvalid = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic        cmd_valid, cmd_ready = 1'b1;
  logic [31:0] cmd_data;

  int n_chk = 0, n_fail = 0, pops = 0, mem_lat = 0, lat_cnt = 0;
  logic [7:0] exp_off = 8'd1;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  cmd_ring_ctrl u_cmd_ring_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .run_i(run),
    .engine_active_o(engine_active), .base_addr_i(BASE), .mem_req_o(mem_req),
    .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .cmd_valid_o(cmd_valid), .cmd_data_o(cmd_data), .cmd_ready_i(cmd_ready)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // memory model: data is address tagged with KEY
  always begin
    @(negedge clk); #1;
    if (mem_rvalid) mem_rvalid = 1'b0;
    else if (mem_req) begin
      if (lat_cnt >= mem_lat) begin
        mem_rvalid = 1'b1;
        mem_rdata  = mem_addr ^ KEY;
        lat_cnt    = 0;
      end else lat_cnt++;
    end
  end

  // consumer: ring order and addresses, R3 / R5
  always begin
    @(negedge clk); #1;
    if (rst_n && cmd_valid && cmd_ready) begin
      check(cmd_data == ((BASE + {22'd0, exp_off, 2'b00}) ^ KEY), "R3/R5 data",
            cmd_data, (BASE + {22'd0, exp_off, 2'b00}) ^ KEY);
      exp_off++;
      pops++;
    end
  end

  task automatic wr(input logic sel, input logic [15:0] d);
    @(negedge clk); reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [15:0] d);
    @(negedge clk); reg_sel = sel; #2 d = reg_rdata;
  endtask

  task automatic wait_rp(input logic [7:0] target);
    logic [15:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd(1'b1, v);
      if (v[7:0] == target) break;
    end
    repeat (8) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [15:0] v;
    int p0;
    bit bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(1'b0, v); check(v == 16'h0000, "R1 wp reg", v, 16'h0000);
    rd(1'b1, v); check(v == 16'h0000, "R1 rp reg", v, 16'h0000);
    check(!mem_req && !cmd_valid, "R1 outputs idle", {mem_req, cmd_valid}, 0);

    // R2 reserved bits, R7 read-only read pointer (run low)
    wr(1'b0, 16'hFF12); rd(1'b0, v); check(v == 16'h0012, "R2 wp reserved", v, 16'h0012);
    wr(1'b0, 16'h0000);
    wr(1'b1, 16'h7F55); rd(1'b1, v); check(v == 16'h0000, "R7 rp read-only", v, 16'h0000);

    // table walk, writes while running (R2, R4, R5)
    run = 1'b1;
    for (int i = 0; i < NVEC; i++) begin
      p0 = pops;
      wr(1'b0, {8'h00, VEC[i][15:8]});
      wait_rp(VEC[i][15:8]);
      rd(1'b1, v);
      check(v[7:0] == VEC[i][15:8], "R4 rp reaches wp", v, {8'h00, VEC[i][15:8]});
      check(pops - p0 == int'(VEC[i][7:0]), "R5 dword count", pops - p0, VEC[i][7:0]);
      check(!mem_req, "R4 idle at wp", mem_req, 0);
    end

    // R5 full buffer stops fetching (rp=2)
    cmd_ready = 1'b0;
    wr(1'b0, 16'h0014);
    repeat (40) @(negedge clk);
    rd(1'b1, v); check(v == 16'h0006, "R5 full stop rp", v, 16'h0006);
    check(cmd_valid && !mem_req, "R5 full no req", {cmd_valid, mem_req}, 2'b10);

    // R10 reset while running is ignored
    wr(1'b1, 16'h8000); #2 v = reg_rdata;
    check(v == 16'h0006, "R10 ignored next", v, 16'h0006);
    rd(1'b1, v); check(v == 16'h0006, "R10 ignored later", v, 16'h0006);
    check(cmd_valid, "R10 buffer kept", cmd_valid, 1);

    // R8 reset while stopped
    run = 1'b0;
    @(negedge clk);
    check(!engine_active, "R6 stopped", engine_active, 0);
    wr(1'b1, 16'h8000); #2 v = reg_rdata;
    check(v == 16'h0000, "R8 flag low first cycle", v, 16'h0000);
    check(!cmd_valid, "R8 buffer flushed", cmd_valid, 0);
    exp_off = 8'd1;
    @(negedge clk); #2 v = reg_rdata;
    check(v == 16'h8000, "R8 flag high", v, 16'h8000);

    // R9 no fetch while flag held, then clear
    run = 1'b1; cmd_ready = 1'b1;
    bad = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); #2 if (mem_req) bad = 1'b1;
    end
    check(!bad, "R9 hold blocks fetch", bad, 0);
    wr(1'b1, 16'h0000); #2 v = reg_rdata;
    check(v == 16'h0000, "R9 flag cleared", v, 16'h0000);
    p0 = pops;
    wait_rp(8'd20);
    check(pops - p0 == 20, "R9 fetch resumes", pops - p0, 20);

    // R6 stop during a slow fetch
    mem_lat = 6;
    wr(1'b0, 16'h001E);
    for (int i = 0; i < 50; i++) begin
      @(negedge clk); #2 if (mem_req) break;
    end
    run = 1'b0;
    @(negedge clk); #2
    check(engine_active && mem_req, "R6 in flight active", {engine_active, mem_req}, 2'b11);
    for (int i = 0; i < 50; i++) begin
      @(negedge clk); #2 if (!mem_req) break;
    end
    check(!engine_active, "R6 stopped after return", engine_active, 0);
    bad = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); #2 if (mem_req) bad = 1'b1;
    end
    check(!bad, "R6 no new req", bad, 0);
    rd(1'b1, v); check(v == 16'h0015, "R6 rp after stop", v, 16'h0015);
    run = 1'b1;
    wait_rp(8'd30);
    rd(1'b1, v); check(v == 16'h001E, "R6 resume", v, 16'h001E);
    mem_lat = 0;

    summary();
  end
endmodule